// File: doc/BRIEF.md
# Dual-Wiring Cartridge Bank Switch Latch

This block sits on the cartridge side of an 8-bit console CPU bus. A CPU write anywhere in the upper half of the 16-bit address space is captured as a 16-bit word. The upper byte of that word is the address high byte and the lower byte is the data byte. In the cycle after capture the word is decoded, and the decode may update one of two bank registers: the switchable 16 KiB program bank or the 8 KiB graphics bank.

The same board was wired two ways, so the decode runs in one of two variants. A captured word of 0x9000 or more uses one set of upper-nibble codes. A word below 0x9000 uses the other set. Bits 7:4 of the word give the code. Bits 3:0 give the bank number.

The lower 16 KiB program window is pinned to bank 0. The block builds the ROM addresses for both windows and for graphics from the bank registers and the incoming bus addresses. All pins are plain control and address signals. There is no streaming interface, so no back-pressure applies.

Top module: `cart_bank_latch`

## Requirements
- R1: After reset the captured word is 0x80B0, and both the program bank and the graphics bank read 0.
- R2: A write with cpu_addr[15]=0 does not change the captured word, and it leaves both banks unchanged.
- R3: When the captured word is 0x9000 or more and bits 7:4 equal 0xD, the program bank becomes bits 3:0.
- R4: When the captured word is 0x9000 or more and bits 7:4 equal 0xE, the graphics bank becomes bits 3:0.
- R5: When the captured word is below 0x9000 and bits 7:4 equal 0xB, the program bank becomes bits 3:0.
- R6: When the captured word is below 0x9000 and bits 7:4 equal 0x7, the graphics bank becomes bits 3:0.
- R7: Any other code leaves both banks unchanged. This includes a code that is valid only in the other variant. One write never changes both banks.
- R8: The variant boundary is exact. A word of 0x8FFF decodes as the low variant and 0x9000 decodes as the high variant.
- R9: A write sampled at clock edge N is captured at edge N. The bank register it selects updates at edge N+1. Writes on consecutive cycles each take effect, in order.
- R10: prg_rom_addr is {0, cpu_addr[13:0]} when cpu_addr[14]=0, and {program bank, cpu_addr[13:0]} when cpu_addr[14]=1.
- R11: gfx_rom_addr is {graphics bank, ppu_addr[12:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Graphics bus address |
| prg_bank | output | 4 | Current switchable program bank |
| gfx_bank | output | 4 | Current graphics bank |
| prg_rom_addr | output | 18 | Program ROM address |
| gfx_rom_addr | output | 17 | Graphics ROM address |

## Verification
Two functions can fall in the same cycle. The capture stage can take a new word while the decode stage is still applying the previous one. The bench provokes this with writes on consecutive cycles: a program select followed at once by a graphics select, and a valid code followed by an ignored code. Every expected bank pair is queued against the cycle in which it must appear. Each pair is compared two edges after its write, so a lost or reordered update shows up in the cycle it happens.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int BANK_W = 4;
  localparam logic [3:0] HI_PRG_CODE = 4'hD;
  localparam logic [3:0] HI_GFX_CODE = 4'hE;
  localparam logic [3:0] LO_PRG_CODE = 4'hB;
  localparam logic [3:0] LO_GFX_CODE = 4'h7;

  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_PRG = 2'd1, TGT_GFX = 2'd2} tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [BANK_W-1:0] bank;
  } upd_t;
endpackage

// File: rtl/cbl_capture.sv
module cbl_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_WORD = 16'h80B0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] word,
  output logic              fresh
);
  localparam int HI_W = ADDR_W - DATA_W;
  logic hit;
  assign hit = wr && addr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= RESET_WORD;
      fresh <= 1'b0;
    end else begin
      fresh <= hit;
      if (hit) word <= {addr[ADDR_W-1 -: HI_W], data};
    end
  end

  // R2: a write outside the upper window leaves the captured word alone
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr[ADDR_W-1]) |=> $stable(word));
endmodule

// File: rtl/cbl_decode.sv
module cbl_decode
  import cbl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] THRESH = 16'h9000
) (
  input  logic [ADDR_W-1:0] word,
  input  logic              fresh,
  output upd_t              upd
);
  logic       hi_var;
  logic [3:0] code;

  assign hi_var = (word >= THRESH);
  assign code   = word[7:4];

  always_comb begin
    upd.bank = word[BANK_W-1:0];
    upd.tgt  = TGT_NONE;
    if (fresh) begin
      if (hi_var) begin
        if (code == HI_PRG_CODE)      upd.tgt = TGT_PRG;
        else if (code == HI_GFX_CODE) upd.tgt = TGT_GFX;
      end else begin
        if (code == LO_PRG_CODE)      upd.tgt = TGT_PRG;
        else if (code == LO_GFX_CODE) upd.tgt = TGT_GFX;
      end
    end
  end
endmodule

// File: rtl/cbl_bank_regs.sv
module cbl_bank_regs
  import cbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  upd_t              upd,
  output logic [BANK_W-1:0] prg_bank,
  output logic [BANK_W-1:0] gfx_bank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_bank <= '0;
      gfx_bank <= '0;
    end else begin
      if (upd.tgt == TGT_PRG) prg_bank <= upd.bank;
      if (upd.tgt == TGT_GFX) gfx_bank <= upd.bank;
    end
  end

  // R7: one decoded write moves at most one bank
  assert_single_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !(prg_bank != $past(prg_bank) && gfx_bank != $past(gfx_bank)));
  // R1: reset values
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (prg_bank == '0 && gfx_bank == '0));
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cbl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PRG_OFS_W = 14,
  parameter int GFX_OFS_W = 13,
  parameter logic [ADDR_W-1:0] THRESH = 16'h9000,
  parameter logic [ADDR_W-1:0] RESET_WORD = 16'h80B0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_wr,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_data,
  input  logic [GFX_OFS_W-1:0]          ppu_addr,
  output logic [BANK_W-1:0]             prg_bank,
  output logic [BANK_W-1:0]             gfx_bank,
  output logic [BANK_W+PRG_OFS_W-1:0]   prg_rom_addr,
  output logic [BANK_W+GFX_OFS_W-1:0]   gfx_rom_addr
);
  logic [ADDR_W-1:0] word;
  logic              fresh;
  upd_t              upd;
  logic [BANK_W-1:0] win_bank;

  cbl_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_WORD(RESET_WORD)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr), .data(cpu_data),
    .word(word), .fresh(fresh));

  cbl_decode #(.ADDR_W(ADDR_W), .THRESH(THRESH)) u_dec (
    .word(word), .fresh(fresh), .upd(upd));

  cbl_bank_regs u_regs (
    .clk(clk), .rst_n(rst_n), .upd(upd), .prg_bank(prg_bank), .gfx_bank(gfx_bank));

  assign win_bank     = cpu_addr[PRG_OFS_W] ? prg_bank : '0;
  assign prg_rom_addr = {win_bank, cpu_addr[PRG_OFS_W-1:0]};
  assign gfx_rom_addr = {gfx_bank, ppu_addr};

  // R3 / R5: program select in either variant loads the low nibble
  assert_prg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && ((word >= THRESH && word[7:4] == HI_PRG_CODE) ||
               (word <  THRESH && word[7:4] == LO_PRG_CODE)))
    |=> prg_bank == $past(word[BANK_W-1:0]));
  // R4 / R6: graphics select in either variant loads the low nibble
  assert_gfx_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && ((word >= THRESH && word[7:4] == HI_GFX_CODE) ||
               (word <  THRESH && word[7:4] == LO_GFX_CODE)))
    |=> gfx_bank == $past(word[BANK_W-1:0]));
  // R7: nothing new to decode, nothing moves
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh |=> ($stable(prg_bank) && $stable(gfx_bank)));
  // R10: lower program window pinned to bank 0
  always_comb begin
    if (rst_n && !cpu_addr[PRG_OFS_W])
      assert_fixed_window_R10: assert (prg_rom_addr[BANK_W+PRG_OFS_W-1:PRG_OFS_W] == '0);
  end
endmodule

// File: tb/tb_cart_bank_latch.sv
module tb_cart_bank_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic [12:0] ppu_addr = 13'h0000;
  logic [3:0]  prg_bank, gfx_bank;
  logic [17:0] prg_rom_addr;
  logic [16:0] gfx_rom_addr;

  cart_bank_latch dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
    .gfx_bank(gfx_bank), .prg_rom_addr(prg_rom_addr), .gfx_rom_addr(gfx_rom_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int       due;
    logic [3:0] prg;
    logic [3:0] gfx;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  logic [15:0] m_word = 16'h80B0;
  logic [3:0]  m_prg = 4'h0, m_gfx = 4'h0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected items as they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check(prg_bank == e.prg, {e.tag, " prg"}, prg_bank, e.prg);
      check(gfx_bank == e.gfx, {e.tag, " gfx"}, gfx_bank, e.gfx);
    end
  end

  // driver: one write cycle, model updated from the requirements
  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    if (a[15]) begin
      m_word = {a[15:8], d};
      if (m_word >= 16'h9000) begin
        if (m_word[7:4] == 4'hD) m_prg = m_word[3:0];
        else if (m_word[7:4] == 4'hE) m_gfx = m_word[3:0];
      end else begin
        if (m_word[7:4] == 4'hB) m_prg = m_word[3:0];
        else if (m_word[7:4] == 4'h7) m_gfx = m_word[3:0];
      end
    end
    e.due = cyc + 2; e.prg = m_prg; e.gfx = m_gfx; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_wr = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(prg_bank == 4'h0, "R1 reset prg", prg_bank, 0);
    check(gfx_bank == 4'h0, "R1 reset gfx", gfx_bank, 0);

    wr_cycle(16'h90FF, 8'hD3, "R3 high prg");        idle(3);
    wr_cycle(16'hFF00, 8'hE9, "R4 high gfx");        idle(3);
    wr_cycle(16'h80FF, 8'hB4, "R5 low prg");         idle(3);
    wr_cycle(16'h8500, 8'h7A, "R6 low gfx");         idle(3);
    wr_cycle(16'h9000, 8'hB6, "R7 low code in high"); idle(3);
    wr_cycle(16'h8800, 8'hE2, "R7 high code in low"); idle(3);
    wr_cycle(16'hA000, 8'h35, "R7 other code");      idle(3);
    wr_cycle(16'h7000, 8'hB5, "R2 below window");    idle(3);
    wr_cycle(16'h8F00, 8'hDC, "R8 0x8FDC low");      idle(3);
    wr_cycle(16'h9000, 8'hDC, "R8 0x90DC high");     idle(3);
    // R9: back-to-back writes overlap capture and decode
    wr_cycle(16'hC000, 8'hD1, "R9 b2b prg");
    wr_cycle(16'hC000, 8'hE7, "R9 b2b gfx");
    wr_cycle(16'hC000, 8'h45, "R9 b2b none");
    wr_cycle(16'h8000, 8'h7F, "R9 b2b low gfx");
    idle(4);

    // R10 / R11 address composition
    cpu_addr = 16'h8123; ppu_addr = 13'h1ABC;
    #1;
    check(prg_rom_addr == {4'h0, 14'h0123}, "R10 fixed window", prg_rom_addr, {4'h0, 14'h0123});
    check(gfx_rom_addr == {m_gfx, 13'h1ABC}, "R11 gfx addr", gfx_rom_addr, {m_gfx, 13'h1ABC});
    cpu_addr = 16'hC456;
    #1;
    check(prg_rom_addr == {m_prg, 14'h0456}, "R10 switch window", prg_rom_addr, {m_prg, 14'h0456});
    idle(2);
    check(q.size() == 0, "R9 queue drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule